// File: doc/BRIEF.md
# Supply Rail Power History Monitor

This block watches a single supply rail. An external converter delivers paired current and voltage samples, each marked by a one-cycle valid strobe. The block latches the newest pair into a readable register and keeps a windowed mean of each field over the most recent 1024 samples. It also forms a relative power figure from the product of voltage and current.

Two circular history memories record successive raw voltages and power figures. A control bit lets software stop recording, so the captured history stays unchanged while it is read out. The present and average registers keep tracking the rail while recording is stopped. All access goes through a simple address/data bus with a one-cycle read latency.

The averaging window is driven by a two-state machine. In `PH_WARM` the window store is not yet full and missing entries count as zero. The transition `WARM_TO_FULL` fires when the 1024th sample is accepted. In `PH_FULL` every new sample displaces the oldest one. `PH_FULL` is held until reset.

Word address map, with `ADDR_W = 11`: `0x000` control, `0x001` present reading, `0x002` average, `0x200`–`0x3FF` voltage history, `0x400`–`0x5FF` power history. Every other address reads as zero.

Top module: `rail_power_monitor`

## Requirements
- R1: On each cycle with `smp_valid` high, the present register at word `0x001` takes the value {current in [31:16], voltage in [15:0]}. Writes to this address have no effect.
- R2: The average register at word `0x002` has the same packing. Each field holds the sum of that field over the last 1024 accepted samples, shifted right by 10. Before 1024 samples have arrived, the missing window entries count as zero.
- R3: Each recorded sample writes its voltage into the voltage history at the current pointer. The pointer then steps by one and wraps from 511 to 0, so the oldest entry is overwritten.
- R4: In the same recorded sample, the power history at the same index receives the upper 16 bits of the 32-bit product voltage × current.
- R5: A history read returns the stored value in bits [15:0]. Bits [31:16] read as zero.
- R6: Control bit 0 enables recording and is 1 after reset. While it is 0, neither history memory is written and the pointer holds. The present and average registers keep updating.
- R7: Control bits [31:1] have no effect on behaviour and read back as the last value written.
- R8: Read data appears on `bus_rdata` one clock after the address is presented. A history read in the same cycle as a write to that entry returns the previous contents.
- R9: A read of any address outside the map returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_cur | input | 16 | Current field of the sample |
| smp_volt | input | 16 | Voltage field of the sample |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |

## Verification
The assertions check the following on every cycle:
- the present register takes each strobed sample;
- the history pointer steps by exactly one per recorded sample and holds while recording is off or no sample arrives;
- history reads never carry nonzero upper bits;
- the window machine never leaves `PH_FULL`.

The following can only be shown by the bench scenarios, against its own model of the sample stream:
- the averaged values, both before and after the window fills;
- the truncated power product;
- wrap-around overwrite of the oldest entry;
- frozen history contents;
- reserved-bit readback;
- the old-data result of a read that collides with a write.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
    typedef enum logic {
        PH_WARM,
        PH_FULL
    } win_phase_e;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_CTRL,
        RD_NOW,
        RD_AVG,
        RD_VHIST,
        RD_PHIST
    } rd_sel_e;
endpackage

// File: rtl/rpm_window.sv
module rpm_window
    import rpm_pkg::*;
#(
    parameter int W       = 16,
    parameter int LOG_WIN = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_cur,
    input  logic [W-1:0] in_volt,
    output logic [W-1:0] avg_cur,
    output logic [W-1:0] avg_volt,
    output win_phase_e   phase
);
    localparam int DEPTH = 1 << LOG_WIN;
    localparam int SUM_W = W + LOG_WIN;

    logic [2*W-1:0]     store [DEPTH];
    logic [LOG_WIN-1:0] wptr;
    logic [SUM_W-1:0]   sum_c, sum_v;
    logic [2*W-1:0]     leaving;
    win_phase_e         state, state_n;

    // Slots not yet filled count as zero.
    assign leaving = (state == PH_FULL) ? store[wptr] : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_WARM;
        else        state <= state_n;
    end

    // Next state: WARM_TO_FULL on the sample that fills the last slot
    always_comb begin
        state_n = state;
        unique case (state)
            PH_WARM: if (in_valid && (wptr == LOG_WIN'(DEPTH - 1))) state_n = PH_FULL;
            PH_FULL: state_n = PH_FULL;
        endcase
    end

    // Outputs
    always_comb begin
        phase    = state;
        avg_cur  = sum_c[SUM_W-1:LOG_WIN];
        avg_volt = sum_v[SUM_W-1:LOG_WIN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            sum_c <= '0;
            sum_v <= '0;
        end else if (in_valid) begin
            wptr  <= wptr + 1'b1;
            sum_c <= sum_c + SUM_W'(in_cur)  - SUM_W'(leaving[2*W-1:W]);
            sum_v <= sum_v + SUM_W'(in_volt) - SUM_W'(leaving[W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) store[wptr] <= {in_cur, in_volt};
    end
endmodule

// File: rtl/rpm_hist_ram.sv
module rpm_hist_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Read-before-write: a colliding read sees the old word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rail_power_monitor.sv
module rail_power_monitor
    import rpm_pkg::*;
#(
    parameter int W          = 16,
    parameter int LOG_WIN    = 10,
    parameter int HIST_DEPTH = 512,
    parameter int ADDR_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [W-1:0]      smp_cur,
    input  logic [W-1:0]      smp_volt,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int HAW = $clog2(HIST_DEPTH);
    localparam int RW  = ADDR_W - HAW;

    logic [31:0]     ctrl_q;
    logic [2*W-1:0]  now_q;
    logic            rec_en;
    logic [HAW-1:0]  hist_ptr;
    logic            hist_we;
    logic [2*W-1:0]  prod;
    logic [W-1:0]    avg_cur, avg_volt;
    logic [W-1:0]    vh_rdata, ph_rdata;
    win_phase_e      win_phase;
    rd_sel_e         rd_sel, rd_sel_q;
    logic [31:0]     reg_q;
    logic [RW-1:0]   region;
    logic [HAW-1:0]  offs;

    assign rec_en  = ctrl_q[0];
    assign hist_we = smp_valid && rec_en;
    assign prod    = smp_volt * smp_cur;
    assign region  = bus_addr[ADDR_W-1:HAW];
    assign offs    = bus_addr[HAW-1:0];

    rpm_window #(.W(W), .LOG_WIN(LOG_WIN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (smp_valid),
        .in_cur   (smp_cur),
        .in_volt  (smp_volt),
        .avg_cur  (avg_cur),
        .avg_volt (avg_volt),
        .phase    (win_phase)
    );

    rpm_hist_ram #(.W(W), .DEPTH(HIST_DEPTH)) u_volt_hist (
        .clk   (clk),
        .we    (hist_we),
        .waddr (hist_ptr),
        .wdata (smp_volt),
        .raddr (offs),
        .rdata (vh_rdata)
    );

    rpm_hist_ram #(.W(W), .DEPTH(HIST_DEPTH)) u_pwr_hist (
        .clk   (clk),
        .we    (hist_we),
        .waddr (hist_ptr),
        .wdata (prod[2*W-1:W]),
        .raddr (offs),
        .rdata (ph_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= 32'h1;
            now_q    <= '0;
            hist_ptr <= '0;
        end else begin
            if (bus_en && bus_we && (region == '0) && (offs == '0))
                ctrl_q <= bus_wdata;
            if (smp_valid) now_q <= {smp_cur, smp_volt};
            if (hist_we)   hist_ptr <= hist_ptr + 1'b1;
        end
    end

    // Read decode
    always_comb begin
        rd_sel = RD_NONE;
        if (bus_en && !bus_we) begin
            if (region == RW'(1))      rd_sel = RD_VHIST;
            else if (region == RW'(2)) rd_sel = RD_PHIST;
            else if (region == '0) begin
                if (offs == HAW'(0))      rd_sel = RD_CTRL;
                else if (offs == HAW'(1)) rd_sel = RD_NOW;
                else if (offs == HAW'(2)) rd_sel = RD_AVG;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sel_q <= RD_NONE;
            reg_q    <= '0;
        end else begin
            rd_sel_q <= rd_sel;
            unique case (rd_sel)
                RD_CTRL: reg_q <= ctrl_q;
                RD_NOW:  reg_q <= 32'(now_q);
                RD_AVG:  reg_q <= 32'({avg_cur, avg_volt});
                default: reg_q <= '0;
            endcase
        end
    end

    always_comb begin
        unique case (rd_sel_q)
            RD_VHIST: bus_rdata = 32'(vh_rdata);
            RD_PHIST: bus_rdata = 32'(ph_rdata);
            RD_NONE:  bus_rdata = '0;
            default:  bus_rdata = reg_q;
        endcase
    end
endmodule

// File: rtl/rpm_chk.sv
module rpm_chk
    import rpm_pkg::*;
#(
    parameter int W      = 16,
    parameter int HAW    = 9,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [W-1:0]      smp_cur,
    input logic [W-1:0]      smp_volt,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              rec_en,
    input logic [HAW-1:0]    hist_ptr,
    input logic [2*W-1:0]    now_q,
    input win_phase_e        win_phase
);
    p_present_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> now_q == {$past(smp_cur), $past(smp_volt)});

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rec_en) |=> hist_ptr == HAW'($past(hist_ptr) + 1'b1));

    p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid || !rec_en) |=> $stable(hist_ptr));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && (bus_addr[ADDR_W-1:HAW] != '0)) |=> bus_rdata[31:16] == 16'h0);

    p_full_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_phase == PH_FULL) |=> (win_phase == PH_FULL));
endmodule

bind rail_power_monitor rpm_chk #(.W(W), .HAW(HAW), .ADDR_W(ADDR_W)) u_rpm_chk (.*);

// File: tb/test_rail_power_monitor.sv
module test_rail_power_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_cur = '0, smp_volt = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0, checks = 0;
    int n = 0;    // samples sent
    int rc = 0;   // samples recorded
    logic [15:0] sc [4096];
    logic [15:0] sv [4096];
    logic [15:0] mv [512];
    logic [15:0] mp [512];
    logic [31:0] rd;

    always #2 clk = ~clk;

    rail_power_monitor i_rail_power_monitor (.*);

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] c, input logic [15:0] v, input bit rec);
        @(negedge clk);
        smp_valid = 1'b1; smp_cur = c; smp_volt = v;
        @(negedge clk);
        smp_valid = 1'b0;
        sc[n] = c; sv[n] = v; n++;
        if (rec) begin
            mv[rc % 512] = v;
            mp[rc % 512] = 16'((32'(v) * 32'(c)) >> 16);
            rc++;
        end
    endtask

    task automatic rd_bus(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr_bus(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    function automatic logic [31:0] avg_model();
        longint s_c = 0, s_v = 0;
        int lo = (n > 1024) ? n - 1024 : 0;
        for (int j = lo; j < n; j++) begin
            s_c += sc[j];
            s_v += sv[j];
        end
        return {16'(s_c >> 10), 16'(s_v >> 10)};
    endfunction

    localparam logic [31:0] VEC [8] = '{
        32'h0001_0002, 32'hFFFF_FFFF, 32'h8000_0002, 32'h1234_5678,
        32'h0000_FFFF, 32'hFFFF_0000, 32'hA5A5_5A5A, 32'h7FFF_8001
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd_bus(11'h000, rd); chk("R6 ctrl reset", rd, 32'h1);
        rd_bus(11'h001, rd); chk("R1 present reset", rd, 32'h0);
        rd_bus(11'h002, rd); chk("R2 avg reset", rd, 32'h0);
        rd_bus(11'h7FF, rd); chk("R9 unmapped", rd, 32'h0);
        rd_bus(11'h003, rd); chk("R9 unmapped reg slot", rd, 32'h0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            push(VEC[i][31:16], VEC[i][15:0], 1'b1);
            rd_bus(11'h001, rd); chk("R1 present", rd, VEC[i]);
            rd_bus(11'h200 + 11'((rc - 1) % 512), rd); chk("R3 R5 volt hist", rd, {16'h0, mv[(rc - 1) % 512]});
            rd_bus(11'h400 + 11'((rc - 1) % 512), rd); chk("R4 R5 power hist", rd, {16'h0, mp[(rc - 1) % 512]});
            rd_bus(11'h002, rd); chk("R2 avg warm", rd, avg_model());
        end

        // Present register ignores writes
        wr_bus(11'h001, 32'hDEAD_BEEF);
        rd_bus(11'h001, rd); chk("R1 write ignored", rd, VEC[7]);

        // Fill past the window and wrap the history
        for (int i = 0; i < 1100; i++)
            push(16'((i * 997 + 13) & 16'hFFFF), 16'((i * 91 + 5) & 16'hFFFF), 1'b1);
        rd_bus(11'h002, rd); chk("R2 avg full window", rd, avg_model());
        rd_bus(11'h200 + 11'((rc - 1) % 512), rd); chk("R3 newest", rd, {16'h0, mv[(rc - 1) % 512]});
        rd_bus(11'h200 + 11'(rc % 512), rd); chk("R3 oldest after wrap", rd, {16'h0, mv[rc % 512]});
        rd_bus(11'h400 + 11'(rc % 512), rd); chk("R4 oldest power", rd, {16'h0, mp[rc % 512]});

        // Freeze recording
        wr_bus(11'h000, 32'h0);
        rd_bus(11'h000, rd); chk("R6 ctrl cleared", rd, 32'h0);
        push(16'h4444, 16'h3333, 1'b0);
        push(16'h5555, 16'h6666, 1'b0);
        rd_bus(11'h001, rd); chk("R6 present while frozen", rd, 32'h5555_6666);
        rd_bus(11'h002, rd); chk("R6 avg while frozen", rd, avg_model());
        rd_bus(11'h200 + 11'(rc % 512), rd); chk("R6 volt hist frozen", rd, {16'h0, mv[rc % 512]});
        rd_bus(11'h400 + 11'(rc % 512), rd); chk("R6 power hist frozen", rd, {16'h0, mp[rc % 512]});

        // Reserved bits
        wr_bus(11'h000, 32'hABCD_0001);
        rd_bus(11'h000, rd); chk("R7 reserved readback", rd, 32'hABCD_0001);
        push(16'h0102, 16'h0304, 1'b1);
        rd_bus(11'h200 + 11'((rc - 1) % 512), rd); chk("R7 records with reserved set", rd, {16'h0, mv[(rc - 1) % 512]});
        wr_bus(11'h000, 32'hFFFF_FFFE);
        rd_bus(11'h000, rd); chk("R7 reserved no enable", rd, 32'hFFFF_FFFE);
        push(16'h0A0A, 16'h0B0B, 1'b0);
        rd_bus(11'h200 + 11'(rc % 512), rd); chk("R7 R6 no record", rd, {16'h0, mv[rc % 512]});
        wr_bus(11'h000, 32'h1);

        // Read colliding with a write returns old contents
        begin
            logic [15:0] old_v;
            int slot;
            slot = rc % 512;
            old_v = mv[slot];
            @(negedge clk);
            smp_valid = 1'b1; smp_cur = 16'h2222; smp_volt = 16'h7777;
            bus_en = 1'b1; bus_we = 1'b0; bus_addr = 11'h200 + 11'(slot);
            @(negedge clk);
            smp_valid = 1'b0; bus_en = 1'b0;
            chk("R8 collide old data", bus_rdata, {16'h0, old_v});
            sc[n] = 16'h2222; sv[n] = 16'h7777; n++;
            mv[slot] = 16'h7777; mp[slot] = 16'((32'h7777 * 32'h2222) >> 16); rc++;
            rd_bus(11'h200 + 11'(slot), rd); chk("R8 new data after", rd, {16'h0, 16'h7777});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule